// File: doc/BRIEF.md
# Network Frame Sync Generator

This block derives a continuous serial bit clock from the system clock and lays a frame of bit periods over it. The frame holds one slot (normal framing) or up to four slots (network framing), and each slot is 8 or 16 bit periods long. A main frame sync marks the start of every frame. In network framing, two auxiliary syncs can each be assigned to any slot, so that several external codecs sharing one data line each see a trigger only in their own slot. The auxiliary syncs are meant for the receive clock and receive sync pins, which are idle when both directions share one clock.

Internal clock generation is allowed only in the shared-clock (synchronous) mode. If the block is enabled with that mode off, it flags a configuration error and keeps every output quiet. All sync outputs are one bit period wide and high during the last bit period before their slot. They change only on the system clock edge at which the bit clock rises. The divisor is read continuously. The slot count, word length and framing mode are taken up at frame boundaries only.

Top module: `net_fsync_gen`

## Requirements
- R1: While running, `bclk` is high for `prescale`+1 system clock cycles and then low for `prescale`+1 cycles, so its period is 2*(`prescale`+1) cycles, where `prescale` is an unsigned 8-bit value from 0 to 255.
- R2: Out of reset, and one cycle after `enable` is sampled low, `bclk`, `fsync`, `aux_a_fs` and `aux_b_fs` are all low. `cfg_err` is low out of reset.
- R3: When `enable` is sampled high while `sync_mode` is low, `cfg_err` is high on the next cycle and `bclk` stays low. `cfg_err` returns low one cycle after that condition ends.
- R4: The first rising edge of `bclk` comes `prescale`+1 cycles after `enable` and `sync_mode` are first sampled high together. The first bit period is treated as the last bit of the last slot of a frame, so `fsync` is high during it.
- R5: `fsync` is high for exactly the bit period that holds the last bit of the last slot of each frame, and low for all other bit periods. A frame is (slots per frame)*(word length) bit periods long.
- R6: With `net_mode` low (normal framing), a frame holds one slot whatever `slots_m1` says, and `aux_a_fs` and `aux_b_fs` stay low. With `net_mode` high, a frame holds `slots_m1`+1 slots.
- R7: `word16` low gives 8 bit periods per slot, and `word16` high gives 16 bit periods per slot.
- R8: `aux_a_fs` is high for exactly the last bit period before slot `aux_a_slot` (slot 0 follows the last slot). This holds only in network framing, with `aux_a_en` high and `aux_a_slot` smaller than the slots per frame. `aux_a_en` and `aux_a_slot` are sampled at each `bclk` rising edge.
- R9: `aux_b_fs` follows the same rule as R8, using `aux_b_en` and `aux_b_slot`, independently of the A channel.
- R10: `slots_m1`, `word16` and `net_mode` are sampled only on the `bclk` rising edge that begins slot 0 (and at the first edge after start). A change made mid-frame leaves the rest of the current frame unchanged and applies from the next frame.
- R11: `fsync`, `aux_a_fs` and `aux_b_fs` change only on the system clock edge at which `bclk` rises, or when the block stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator |
| sync_mode | input | 1 | Shared-clock mode; required for internal generation |
| prescale | input | 8 | Divisor value N; bit period = 2*(N+1) clocks |
| net_mode | input | 1 | 1 = network framing, 0 = one slot per frame |
| slots_m1 | input | 2 | Slots per frame minus one (network framing) |
| word16 | input | 1 | 1 = 16-bit slots, 0 = 8-bit slots |
| aux_a_en | input | 1 | Enable auxiliary sync A |
| aux_a_slot | input | 2 | Slot that auxiliary sync A precedes |
| aux_b_en | input | 1 | Enable auxiliary sync B |
| aux_b_slot | input | 2 | Slot that auxiliary sync B precedes |
| bclk | output | 1 | Generated bit clock |
| fsync | output | 1 | Main frame sync, before slot 0 |
| aux_a_fs | output | 1 | Auxiliary slot sync A |
| aux_b_fs | output | 1 | Auxiliary slot sync B |
| cfg_err | output | 1 | Enabled while not in shared-clock mode |

## Verification
Every output is registered. `cfg_err` and the idle state after `enable` falls appear one cycle after the input is sampled. The first `bclk` rise comes `prescale`+1 cycles after start, and the syncs move only on that same edge. The bench samples on the falling system clock edge and follows `bclk`. Each observed rise steps an independent frame position model, and the sync levels are compared at that rise. Bit-clock period and high time are measured in counted cycles and compared with 2*(N+1) and N+1. Every sample between rises is checked for steady sync outputs.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  localparam int SLOT_W  = 2;
  localparam int NUM_AUX = 2;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic  net;
    slot_t last_slot;
    logic  wide;
  } frame_cfg_t;
endpackage

// File: rtl/nfs_prescaler.sv
module nfs_prescaler #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] div_n,
  output logic               bclk,
  output logic               rise_tick
);
  logic [PRESC_W-1:0] pcnt_q, pcnt_d;
  logic               bclk_q, bclk_d;
  logic               wrap;

  assign wrap = (pcnt_q >= div_n);

  always_comb begin
    pcnt_d = pcnt_q;
    bclk_d = bclk_q;
    if (!run) begin
      pcnt_d = '0;
      bclk_d = 1'b0;
    end else if (wrap) begin
      pcnt_d = '0;
      bclk_d = ~bclk_q;
    end else begin
      pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      bclk_q <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign rise_tick = run && wrap && !bclk_q;
  assign bclk      = bclk_q;
endmodule

// File: rtl/nfs_framer.sv
module nfs_framer
  import nfs_pkg::*;
#(
  parameter int SHORT_LEN = 8,
  parameter int LONG_LEN  = 16,
  localparam int BIT_W    = $clog2(LONG_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rise_tick,
  input  frame_cfg_t       cfg_in,
  output slot_t            nxt_slot,
  output logic [BIT_W-1:0] nxt_bit,
  output logic [BIT_W-1:0] nxt_wl_m1,
  output frame_cfg_t       nxt_cfg
);
  logic             started_q, started_d;
  slot_t            slot_q, slot_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  frame_cfg_t       cfg_q, cfg_d;
  logic [BIT_W-1:0] cur_wl_m1;

  function automatic logic [BIT_W-1:0] len_m1(input logic wide);
    return wide ? BIT_W'(LONG_LEN - 1) : BIT_W'(SHORT_LEN - 1);
  endfunction

  assign cur_wl_m1 = len_m1(cfg_q.wide);

  // Position the next bclk rise will enter
  always_comb begin
    nxt_cfg  = cfg_q;
    nxt_slot = slot_q;
    nxt_bit  = bit_q;
    if (!started_q) begin
      nxt_cfg  = cfg_in;
      nxt_slot = cfg_in.last_slot;
      nxt_bit  = len_m1(cfg_in.wide);
    end else if (bit_q == cur_wl_m1) begin
      nxt_bit = '0;
      if (slot_q == cfg_q.last_slot) begin
        nxt_slot = '0;
        nxt_cfg  = cfg_in;
      end else begin
        nxt_slot = slot_t'(slot_q + 1'b1);
      end
    end else begin
      nxt_bit = bit_q + 1'b1;
    end
  end

  assign nxt_wl_m1 = len_m1(nxt_cfg.wide);

  always_comb begin
    started_d = started_q;
    slot_d    = slot_q;
    bit_d     = bit_q;
    cfg_d     = cfg_q;
    if (!run) begin
      started_d = 1'b0;
      slot_d    = '0;
      bit_d     = '0;
    end else if (rise_tick) begin
      started_d = 1'b1;
      slot_d    = nxt_slot;
      bit_d     = nxt_bit;
      cfg_d     = nxt_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      slot_q    <= '0;
      bit_q     <= '0;
      cfg_q     <= '0;
    end else begin
      started_q <= started_d;
      slot_q    <= slot_d;
      bit_q     <= bit_d;
      cfg_q     <= cfg_d;
    end
  end
endmodule

// File: rtl/nfs_sync_dec.sv
module nfs_sync_dec
  import nfs_pkg::*;
#(
  parameter int BIT_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic                          rise_tick,
  input  slot_t                         nxt_slot,
  input  logic [BIT_W-1:0]              nxt_bit,
  input  logic [BIT_W-1:0]              nxt_wl_m1,
  input  frame_cfg_t                    nxt_cfg,
  input  logic [NUM_AUX-1:0]            aux_en,
  input  logic [NUM_AUX-1:0][SLOT_W-1:0] aux_slot,
  output logic                          main_fs,
  output logic [NUM_AUX-1:0]            aux_fs
);
  logic  on_last, frame_end;
  slot_t upcoming;
  logic  main_q, main_d;

  assign on_last   = (nxt_bit == nxt_wl_m1);
  assign frame_end = (nxt_slot == nxt_cfg.last_slot);
  assign upcoming  = frame_end ? '0 : slot_t'(nxt_slot + 1'b1);

  always_comb begin
    main_d = main_q;
    if (!run)           main_d = 1'b0;
    else if (rise_tick) main_d = on_last && frame_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) main_q <= 1'b0;
    else        main_q <= main_d;
  end

  assign main_fs = main_q;

  for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
    logic hit, fs_q, fs_d;

    assign hit = nxt_cfg.net && aux_en[g] && on_last &&
                 (upcoming == aux_slot[g]) &&
                 (aux_slot[g] <= nxt_cfg.last_slot);

    always_comb begin
      fs_d = fs_q;
      if (!run)           fs_d = 1'b0;
      else if (rise_tick) fs_d = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fs_q <= 1'b0;
      else        fs_q <= fs_d;
    end

    assign aux_fs[g] = fs_q;
  end
endmodule

// File: rtl/net_fsync_gen.sv
module net_fsync_gen
  import nfs_pkg::*;
#(
  parameter int PRESC_W   = 8,
  parameter int SHORT_LEN = 8,
  parameter int LONG_LEN  = 16,
  localparam int BIT_W    = $clog2(LONG_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               sync_mode,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               net_mode,
  input  logic [SLOT_W-1:0]  slots_m1,
  input  logic               word16,
  input  logic               aux_a_en,
  input  logic [SLOT_W-1:0]  aux_a_slot,
  input  logic               aux_b_en,
  input  logic [SLOT_W-1:0]  aux_b_slot,
  output logic               bclk,
  output logic               fsync,
  output logic               aux_a_fs,
  output logic               aux_b_fs,
  output logic               cfg_err
);
  logic                           run, rise_tick;
  frame_cfg_t                     cfg_in, nxt_cfg;
  slot_t                          nxt_slot;
  logic [BIT_W-1:0]               nxt_bit, nxt_wl_m1;
  logic [NUM_AUX-1:0]             aux_en_v, aux_fs_v;
  logic [NUM_AUX-1:0][SLOT_W-1:0] aux_slot_v;
  logic                           err_q, err_d;

  assign run              = enable && sync_mode;
  assign cfg_in.net       = net_mode;
  assign cfg_in.last_slot = net_mode ? slots_m1 : '0;
  assign cfg_in.wide      = word16;
  assign aux_en_v         = {aux_b_en, aux_a_en};
  assign aux_slot_v       = {aux_b_slot, aux_a_slot};

  nfs_prescaler #(.PRESC_W(PRESC_W)) presc_i (
    .clk(clk), .rst_n(rst_n), .run(run), .div_n(prescale),
    .bclk(bclk), .rise_tick(rise_tick)
  );

  nfs_framer #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) framer_i (
    .clk(clk), .rst_n(rst_n), .run(run), .rise_tick(rise_tick),
    .cfg_in(cfg_in), .nxt_slot(nxt_slot), .nxt_bit(nxt_bit),
    .nxt_wl_m1(nxt_wl_m1), .nxt_cfg(nxt_cfg)
  );

  nfs_sync_dec #(.BIT_W(BIT_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .run(run), .rise_tick(rise_tick),
    .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .nxt_wl_m1(nxt_wl_m1),
    .nxt_cfg(nxt_cfg), .aux_en(aux_en_v), .aux_slot(aux_slot_v),
    .main_fs(fsync), .aux_fs(aux_fs_v)
  );

  assign aux_a_fs = aux_fs_v[0];
  assign aux_b_fs = aux_fs_v[1];

  assign err_d = enable && !sync_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign cfg_err = err_q;
endmodule

// File: rtl/nfs_checker.sv
module nfs_checker #(
  parameter int PRESC_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               sync_mode,
  input logic [PRESC_W-1:0] prescale,
  input logic               aux_a_en,
  input logic               aux_b_en,
  input logic               bclk,
  input logic               fsync,
  input logic               aux_a_fs,
  input logic               aux_b_fs,
  input logic               cfg_err
);
  logic             run;
  logic             prev_q;
  logic [PRESC_W:0] hold_q;

  assign run = enable && sync_mode;

  // Counts cycles that bclk has kept its level while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= '0;
    end else begin
      prev_q <= bclk;
      if (!run || (bclk != prev_q)) hold_q <= '0;
      else                          hold_q <= hold_q + 1'b1;
    end
  end

  assert_bclk_halfper_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (bclk == prev_q)) |-> (hold_q <= {1'b0, prescale}));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bclk && !fsync && !aux_a_fs && !aux_b_fs));

  assert_async_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !sync_mode) |=> (cfg_err && !bclk));

  assert_fsync_on_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fsync) && $past(run)) |-> $rose(bclk));

  assert_auxa_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_a_fs) |-> ($past(aux_a_en) && $rose(bclk)));

  assert_auxb_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_b_fs) |-> ($past(aux_b_en) && $rose(bclk)));
endmodule

bind net_fsync_gen nfs_checker #(.PRESC_W(PRESC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
  .prescale(prescale), .aux_a_en(aux_a_en), .aux_b_en(aux_b_en),
  .bclk(bclk), .fsync(fsync), .aux_a_fs(aux_a_fs), .aux_b_fs(aux_b_fs),
  .cfg_err(cfg_err)
);

// File: tb/net_fsync_gen_tb_top.sv
module net_fsync_gen_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, enable, sync_mode, net_mode, word16;
  logic [7:0] prescale;
  logic [1:0] slots_m1, aux_a_slot, aux_b_slot;
  logic       aux_a_en, aux_b_en;
  logic       bclk, fsync, aux_a_fs, aux_b_fs, cfg_err;

  net_fsync_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
    .prescale(prescale), .net_mode(net_mode), .slots_m1(slots_m1),
    .word16(word16), .aux_a_en(aux_a_en), .aux_a_slot(aux_a_slot),
    .aux_b_en(aux_b_en), .aux_b_slot(aux_b_slot), .bclk(bclk),
    .fsync(fsync), .aux_a_fs(aux_a_fs), .aux_b_fs(aux_b_fs), .cfg_err(cfg_err)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit mon_on = 0;
  string ctx = "";
  int m_started, m_slot, m_bit, m_nsl, m_wl, m_net;
  int rises, last_rise, start_cyc;
  logic p_bclk, p_fs, p_a, p_b;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int aux_exp(input logic en, input logic [1:0] s);
    int up;
    up = (m_slot == m_nsl - 1) ? 0 : m_slot + 1;
    return (m_net != 0 && en && m_bit == m_wl - 1 && up == int'(s) && int'(s) < m_nsl) ? 1 : 0;
  endfunction

  task automatic load_cfg;
    m_net = net_mode;
    m_nsl = net_mode ? int'(slots_m1) + 1 : 1;
    m_wl  = word16 ? 16 : 8;
  endtask

  task automatic monitor;
    int per;
    per = int'(prescale) + 1;
    if (bclk && !p_bclk) begin
      if (rises == 0) chk(cyc - start_cyc == per, {"R4 first rise latency ", ctx}, cyc - start_cyc, per);
      else            chk(cyc - last_rise == 2 * per, {"R1 period ", ctx}, cyc - last_rise, 2 * per);
      last_rise = cyc;
      rises++;
      if (m_started == 0) begin
        m_started = 1; load_cfg();
        m_slot = m_nsl - 1; m_bit = m_wl - 1;
      end else if (m_bit == m_wl - 1) begin
        m_bit = 0;
        if (m_slot == m_nsl - 1) begin m_slot = 0; load_cfg(); end
        else m_slot++;
      end else m_bit++;
      chk(int'(fsync) == ((m_bit == m_wl - 1 && m_slot == m_nsl - 1) ? 1 : 0),
          {"R5 R7 fsync ", ctx}, fsync, (m_bit == m_wl - 1 && m_slot == m_nsl - 1) ? 1 : 0);
      chk(int'(aux_a_fs) == aux_exp(aux_a_en, aux_a_slot), {"R8 R6 aux_a ", ctx},
          aux_a_fs, aux_exp(aux_a_en, aux_a_slot));
      chk(int'(aux_b_fs) == aux_exp(aux_b_en, aux_b_slot), {"R9 R6 aux_b ", ctx},
          aux_b_fs, aux_exp(aux_b_en, aux_b_slot));
    end else begin
      if (!bclk && p_bclk)
        chk(cyc - last_rise == per, {"R1 high time ", ctx}, cyc - last_rise, per);
      chk({fsync, aux_a_fs, aux_b_fs} == {p_fs, p_a, p_b}, {"R11 steady syncs ", ctx},
          int'({fsync, aux_a_fs, aux_b_fs}), int'({p_fs, p_a, p_b}));
    end
  endtask

  task automatic step;
    @(negedge clk);
    cyc++;
    if (mon_on) monitor();
    p_bclk = bclk; p_fs = fsync; p_a = aux_a_fs; p_b = aux_b_fs;
  endtask

  task automatic start_run;
    m_started = 0; rises = 0; start_cyc = cyc; last_rise = cyc;
    p_bclk = bclk; p_fs = fsync; p_a = aux_a_fs; p_b = aux_b_fs;
    sync_mode = 1'b1; mon_on = 1; enable = 1'b1;
  endtask

  task automatic stop_run;
    mon_on = 0; enable = 1'b0;
    step();
    chk({bclk, fsync, aux_a_fs, aux_b_fs} == 4'b0, {"R2 stop idle ", ctx},
        int'({bclk, fsync, aux_a_fs, aux_b_fs}), 0);
    step();
  endtask

  task automatic wait_rises(input int n);
    while (rises < n) step();
  endtask

  task automatic run_cfg(input int n, input bit net, input int sm1, input bit w16,
                         input bit ae, input int as, input bit be, input int bs,
                         input int nbits);
    prescale = 8'(n); net_mode = net; slots_m1 = 2'(sm1); word16 = w16;
    aux_a_en = ae; aux_a_slot = 2'(as); aux_b_en = be; aux_b_slot = 2'(bs);
    start_run();
    wait_rises(nbits);
    stop_run();
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; sync_mode = 1'b0; prescale = '0; net_mode = 1'b0;
    slots_m1 = '0; word16 = 1'b0; aux_a_en = 1'b0; aux_a_slot = '0;
    aux_b_en = 1'b0; aux_b_slot = '0;
    repeat (3) step();
    chk({bclk, fsync, aux_a_fs, aux_b_fs, cfg_err} == 5'b0, "R2 reset state",
        int'({bclk, fsync, aux_a_fs, aux_b_fs, cfg_err}), 0);
    rst_n = 1'b1;
    step();

    // Sweep of divisor, framing, slot count and word length
    for (int n = 0; n <= 2; n += 2)
      for (int net = 0; net < 2; net++)
        for (int sm1 = 0; sm1 < 4; sm1++)
          for (int w = 0; w < 2; w++) begin
            int nsl;
            nsl = net ? sm1 + 1 : 1;
            ctx = net ? "network sweep" : "R6 normal sweep";
            run_cfg(n, net[0], sm1, w[0], 1'b1, (sm1 + w) % 4,
                    (w == 0 || n == 0), (3 - sm1 + net) % 4,
                    nsl * (w ? 16 : 8) * 2 + 2);
          end

    ctx = "odd divisor";
    run_cfg(1, 1'b1, 2, 1'b0, 1'b1, 0, 1'b1, 2, 30);
    ctx = "max divisor";
    run_cfg(255, 1'b1, 1, 1'b0, 1'b1, 1, 1'b1, 0, 6);

    // Mid-frame reconfiguration applies at the next frame
    ctx = "R10 reconfig";
    prescale = 8'd0; net_mode = 1'b1; slots_m1 = 2'd3; word16 = 1'b0;
    aux_a_en = 1'b1; aux_a_slot = 2'd2; aux_b_en = 1'b1; aux_b_slot = 2'd1;
    start_run();
    wait_rises(10);
    slots_m1 = 2'd1; word16 = 1'b1;
    wait_rises(140);
    stop_run();

    // Enable without shared-clock mode
    ctx = "R3 async";
    sync_mode = 1'b0; enable = 1'b1;
    step();
    chk(cfg_err == 1'b1, "R3 cfg_err raised", cfg_err, 1);
    for (int i = 0; i < 20; i++) begin
      step();
      chk({bclk, fsync} == 2'b0, "R3 outputs quiet", int'({bclk, fsync}), 0);
    end
    enable = 1'b0;
    step();
    chk(cfg_err == 1'b0, "R3 cfg_err cleared", cfg_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule